// File: doc/BRIEF.md
# Packetized flash data-port controller

This block is the host-facing register and transfer engine of a NAND flash controller. A host writes a command word, a packet descriptor (size in bytes and number of packets) and a one-hot operation trigger through a 32-bit memory-mapped register interface. The engine then moves data in fixed-size packets between a single-packet buffer and a 32-bit data port. The flash side is modelled as two byte streams, one inbound (flash to engine) and one outbound (engine to flash). The decoded command fields are presented to the flash side as plain outputs.

Each packet is gated by its own event. On a read the host is told when a full packet sits in the buffer. On a program the host is told when the buffer can take the next packet. Completion is flagged only after the last packet. Events pass through a write-one-to-clear status register that has two enable masks: one lets a bit latch, the other lets a latched bit reach the interrupt line. When the command word selects DMA transfer mode, the per-packet events are suppressed and only completion is reported.

Top module: `flash_pkt_port`

## Requirements
- R1: After reset, irq and busy are low, fl_op is zero, fin_ready and fout_valid are low, and the registers at offsets 0x00, 0x0C, 0x14, 0x18 and 0x1C read as zero.
- R2: The command word at 0x0C places opcode one in bits 7:0 (fl_opc1), opcode two in bits 15:8 (fl_opc2), the address-cycle count in bits 31:28 (fl_addr_cycles) and the transfer mode in bits 27:26, where value 2 means DMA (fl_dma). Its page-size code in bits 25:23 is shown on fl_page_bytes as follows: 0 gives 512, 5 gives 1024, 1 gives 2048, 2 gives 4096, 3 gives 8192, 4 gives 16384, and 6 or 7 give 0.
- R3: A write to 0x10 while idle starts an operation only if exactly one of bits 0 (page read), 2 (erase), 3 (read status), 4 (page program), 6 (read ID), 7 (read parameter page), 8 (reset), 9 (get feature) or 10 (set feature) is set and no other bit is set. The operation is shown one-hot on fl_op while busy. Any other pattern starts nothing and raises status bit 4 (error).
- R4: A write to 0x10 while busy is ignored: fl_op is unchanged and no status bit is raised.
- R5: On a read-type operation (bits 0, 3, 6, 7, 9), inbound bytes are packed little-endian into 32-bit words, so the first byte lands in bits 7:0. Status bit 1 (read-ready) is raised each time a full packet is buffered. The packet size is a nonzero multiple of 4, at most MAX_PKT_BYTES, held in bits 10:0 of 0x00. The packet count is held in bits 23:12 of 0x00.
- R6: A read of the data port at 0x30 while no packet is ready returns zero and does not advance the buffer position.
- R7: On a program-type operation (bits 4, 10), status bit 0 (write-ready) is raised each time the buffer can take a packet. After size/4 words are written to 0x30, the bytes leave on the outbound stream little-endian.
- R8: Status bit 2 (transfer-complete) is raised only after the last packet has been drained (read) or consumed (program). Operations that carry no data (erase, reset, or a packet count of 0) complete straight away.
- R9: In DMA mode, neither read-ready nor write-ready is raised, and completion is still raised.
- R10: Writing 1 to a bit of 0x1C clears it. A status bit latches an event only if its bit in 0x14 is set.
- R11: irq is high when some latched status bit also has its bit in 0x18 set, and low otherwise.
- R12: busy stays high in the cycle in which transfer-complete first shows as latched and drops in the next cycle.
- R13: A one-cycle pulse on fl_ecc_err raises status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data port reads advance the buffer) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Operation in progress |
| fl_op | output | 11 | One-hot operation in progress |
| fl_opc1 | output | 8 | First opcode |
| fl_opc2 | output | 8 | Second opcode |
| fl_addr_cycles | output | 4 | Address-cycle count |
| fl_page_bytes | output | 16 | Decoded page size in bytes |
| fl_dma | output | 1 | DMA transfer mode selected |
| fl_ecc_err | input | 1 | Multi-bit ECC error pulse from the flash side |
| fin_valid | input | 1 | Inbound byte valid |
| fin_data | input | 8 | Inbound byte |
| fin_ready | output | 1 | Engine accepts an inbound byte |
| fout_valid | output | 1 | Outbound byte valid |
| fout_data | output | 8 | Outbound byte |
| fout_ready | input | 1 | Flash side accepts the outbound byte |

## Verification
The bench builds the block with MAX_PKT_BYTES set to 16, a four-word buffer, and keeps the default field widths. The small buffer lets a multi-packet page read reach the packet-full boundary, the wrap of the buffer index back to word zero and the refill of a second packet within a few dozen cycles. A 4-byte DMA packet is also run, which exercises the case where the first word is also the last word of the packet.

// File: rtl/flash_pkt_pkg.sv
package flash_pkt_pkg;

    // event / status bit positions
    localparam int EV_W    = 5;
    localparam int EV_WRDY = 0;
    localparam int EV_RRDY = 1;
    localparam int EV_DONE = 2;
    localparam int EV_ECC  = 3;
    localparam int EV_ERR  = 4;

    // operation trigger bits
    localparam int OP_W = 11;
    localparam logic [OP_W-1:0] OP_LEGAL   = 11'b111_1101_1101;
    localparam logic [OP_W-1:0] OP_READERS = 11'b010_1100_1001;
    localparam logic [OP_W-1:0] OP_WRITERS = 11'b100_0001_0000;

    // register offsets
    localparam int OFS_PKT    = 'h00;
    localparam int OFS_CMD    = 'h0C;
    localparam int OFS_PROG   = 'h10;
    localparam int OFS_STS_EN = 'h14;
    localparam int OFS_SIG_EN = 'h18;
    localparam int OFS_STS    = 'h1C;
    localparam int OFS_DATA   = 'h30;

    localparam logic [1:0] MODE_DMA = 2'd2;

    typedef struct packed {
        logic [3:0] addr_cycles;
        logic [1:0] xfer_mode;
        logic [2:0] page_code;
        logic [6:0] rsvd;
        logic [7:0] opc2;
        logic [7:0] opc1;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_LOAD,
        ST_EMIT,
        ST_DONE,
        ST_FIN
    } eng_state_t;

    function automatic logic [15:0] page_bytes(input logic [2:0] code);
        case (code)
            3'd0:    page_bytes = 16'd512;
            3'd5:    page_bytes = 16'd1024;
            3'd1:    page_bytes = 16'd2048;
            3'd2:    page_bytes = 16'd4096;
            3'd3:    page_bytes = 16'd8192;
            3'd4:    page_bytes = 16'd16384;
            default: page_bytes = 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/fpp_irq.sv
module fpp_irq
    import flash_pkt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sts_en_wr,
    input  logic            sig_en_wr,
    input  logic            sts_clr_wr,
    input  logic [EV_W-1:0] wbits,
    input  logic [EV_W-1:0] ev,
    output logic [EV_W-1:0] status,
    output logic [EV_W-1:0] sts_en,
    output logic [EV_W-1:0] sig_en,
    output logic            irq
);

    logic [EV_W-1:0] clr_mask;

    always_comb begin
        clr_mask = sts_clr_wr ? wbits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            sts_en <= '0;
            sig_en <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            status <= (status & ~clr_mask) | (ev & sts_en);
            if (sts_en_wr) sts_en <= wbits;
            if (sig_en_wr) sig_en <= wbits;
        end
    end

    assign irq = |(status & sig_en);

endmodule

// File: rtl/fpp_engine.sv
module fpp_engine
    import flash_pkt_pkg::*;
#(
    parameter int MAX_PKT_BYTES = 64,
    parameter int SIZE_W        = 11,
    parameter int CNT_W         = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   start_op,
    input  logic              start_dma,
    input  logic [SIZE_W-1:0] pkt_bytes,
    input  logic [CNT_W-1:0]  pkt_cnt,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [31:0]       dp_wdata,
    output logic [31:0]       dp_rdata,
    input  logic              fin_valid,
    input  logic [7:0]        fin_data,
    output logic              fin_ready,
    output logic              fout_valid,
    output logic [7:0]        fout_data,
    input  logic              fout_ready,
    output logic [2:0]        ev,
    output logic              busy,
    output logic [OP_W-1:0]   cur_op,
    output logic              cur_dma
);

    localparam int BUF_WORDS = MAX_PKT_BYTES / 4;
    localparam int WIDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam int WCNT_W    = SIZE_W - 2;
    localparam logic [SIZE_W-1:0] ONE_B = 1;
    localparam logic [WCNT_W-1:0] ONE_W = 1;
    localparam logic [CNT_W-1:0]  ONE_P = 1;

    eng_state_t        st, nxt;
    logic [OP_W-1:0]   op_q;
    logic              dma_q;
    logic [SIZE_W-1:0] bsz_q;
    logic [CNT_W-1:0]  left_q;
    logic [SIZE_W-1:0] bcnt_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic [31:0]       buf_q [BUF_WORDS];

    logic              last_byte, last_word, last_pkt, dma_eff;
    logic [WIDX_W-1:0] widx_b, widx_w;
    logic [1:0]        lane;
    logic              is_rd, is_wr;

    assign last_byte = (bcnt_q == bsz_q - ONE_B);
    assign last_word = (wcnt_q == bsz_q[SIZE_W-1:2] - ONE_W);
    assign last_pkt  = (left_q == ONE_P);
    assign widx_b    = bcnt_q[WIDX_W+1:2];
    assign widx_w    = wcnt_q[WIDX_W-1:0];
    assign lane      = bcnt_q[1:0];
    assign is_rd     = |(start_op & OP_READERS);
    assign is_wr     = |(start_op & OP_WRITERS);
    assign dma_eff   = (st == ST_IDLE) ? start_dma : dma_q;

    always_comb begin
        nxt        = st;
        fin_ready  = 1'b0;
        fout_valid = 1'b0;
        dp_rdata   = '0;
        fout_data  = buf_q[widx_b][8*lane +: 8];
        case (st)
            ST_IDLE: begin
                if (start) begin
                    if (pkt_cnt == '0 || !(is_rd || is_wr)) nxt = ST_DONE;
                    else if (is_rd)                         nxt = ST_FILL;
                    else                                    nxt = ST_LOAD;
                end
            end
            ST_FILL: begin
                fin_ready = 1'b1;
                if (fin_valid && last_byte) nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                dp_rdata = buf_q[widx_w];
                if (dp_rd && last_word) nxt = last_pkt ? ST_DONE : ST_FILL;
            end
            ST_LOAD: begin
                if (dp_wr && last_word) nxt = ST_EMIT;
            end
            ST_EMIT: begin
                fout_valid = 1'b1;
                if (fout_ready && last_byte) nxt = last_pkt ? ST_DONE : ST_LOAD;
            end
            ST_DONE: nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        ev[0] = (nxt == ST_LOAD) && (st != ST_LOAD) && !dma_eff;
        ev[1] = (st == ST_FILL) && fin_valid && last_byte && !dma_q;
        ev[2] = (st == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_q   <= '0;
            dma_q  <= 1'b0;
            bsz_q  <= '0;
            left_q <= '0;
            bcnt_q <= '0;
            wcnt_q <= '0;
        end else begin
            st <= nxt;
            case (st)
                ST_IDLE: if (start) begin
                    op_q   <= start_op;
                    dma_q  <= start_dma;
                    bsz_q  <= pkt_bytes;
                    left_q <= pkt_cnt;
                    bcnt_q <= '0;
                    wcnt_q <= '0;
                end
                ST_FILL: if (fin_valid) bcnt_q <= last_byte ? '0 : bcnt_q + ONE_B;
                ST_DRAIN: if (dp_rd) begin
                    wcnt_q <= last_word ? '0 : wcnt_q + ONE_W;
                    if (last_word) left_q <= left_q - ONE_P;
                end
                ST_LOAD: if (dp_wr) wcnt_q <= last_word ? '0 : wcnt_q + ONE_W;
                ST_EMIT: if (fout_ready) begin
                    bcnt_q <= last_byte ? '0 : bcnt_q + ONE_B;
                    if (last_byte) left_q <= left_q - ONE_P;
                end
                ST_FIN: op_q <= '0;
                default: ;
            endcase
        end
    end

    // packet storage, no reset needed
    always_ff @(posedge clk) begin
        if (st == ST_FILL && fin_valid) buf_q[widx_b][8*lane +: 8] <= fin_data;
        if (st == ST_LOAD && dp_wr)     buf_q[widx_w] <= dp_wdata;
    end

    assign busy    = (st != ST_IDLE);
    assign cur_op  = op_q;
    assign cur_dma = dma_q;

endmodule

// File: rtl/flash_pkt_port.sv
module flash_pkt_port
    import flash_pkt_pkg::*;
#(
    parameter int MAX_PKT_BYTES = 64,
    parameter int SIZE_W        = 11,
    parameter int CNT_W         = 12,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              busy,
    output logic [OP_W-1:0]   fl_op,
    output logic [7:0]        fl_opc1,
    output logic [7:0]        fl_opc2,
    output logic [3:0]        fl_addr_cycles,
    output logic [15:0]       fl_page_bytes,
    output logic              fl_dma,
    input  logic              fl_ecc_err,
    input  logic              fin_valid,
    input  logic [7:0]        fin_data,
    output logic              fin_ready,
    output logic              fout_valid,
    output logic [7:0]        fout_data,
    input  logic              fout_ready
);

    localparam int CNT_LSB = 12;

    logic [31:0]     pkt_q;
    cmd_word_t       cmd_q;
    logic            hit_pkt, hit_cmd, hit_prog, hit_sen, hit_gen, hit_sts, hit_data;
    logic            trig_legal, eng_start, trig_err;
    logic [OP_W-1:0] trig_op;
    logic [2:0]      eng_ev;
    logic            eng_dma;
    logic [EV_W-1:0] all_ev, irq_status, sts_en_q, sig_en_q;
    logic [31:0]     dp_rdata;

    assign hit_pkt  = (reg_addr == ADDR_W'(OFS_PKT));
    assign hit_cmd  = (reg_addr == ADDR_W'(OFS_CMD));
    assign hit_prog = (reg_addr == ADDR_W'(OFS_PROG));
    assign hit_sen  = (reg_addr == ADDR_W'(OFS_STS_EN));
    assign hit_gen  = (reg_addr == ADDR_W'(OFS_SIG_EN));
    assign hit_sts  = (reg_addr == ADDR_W'(OFS_STS));
    assign hit_data = (reg_addr == ADDR_W'(OFS_DATA));

    assign trig_op    = reg_wdata[OP_W-1:0];
    assign trig_legal = $onehot(trig_op) && ((trig_op & ~OP_LEGAL) == '0)
                        && (reg_wdata[31:OP_W] == '0);
    assign eng_start  = reg_wr && hit_prog && !busy && trig_legal;
    assign trig_err   = reg_wr && hit_prog && !busy && !trig_legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (reg_wr && hit_pkt) pkt_q <= reg_wdata;
            if (reg_wr && hit_cmd) cmd_q <= cmd_word_t'(reg_wdata);
        end
    end

    fpp_engine #(
        .MAX_PKT_BYTES (MAX_PKT_BYTES),
        .SIZE_W        (SIZE_W),
        .CNT_W         (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .start_op   (trig_op),
        .start_dma  (fl_dma),
        .pkt_bytes  (pkt_q[SIZE_W-1:0]),
        .pkt_cnt    (pkt_q[CNT_LSB +: CNT_W]),
        .dp_rd      (reg_rd && hit_data),
        .dp_wr      (reg_wr && hit_data),
        .dp_wdata   (reg_wdata),
        .dp_rdata   (dp_rdata),
        .fin_valid  (fin_valid),
        .fin_data   (fin_data),
        .fin_ready  (fin_ready),
        .fout_valid (fout_valid),
        .fout_data  (fout_data),
        .fout_ready (fout_ready),
        .ev         (eng_ev),
        .busy       (busy),
        .cur_op     (fl_op),
        .cur_dma    (eng_dma)
    );

    assign all_ev = {trig_err, fl_ecc_err, eng_ev};

    fpp_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .sts_en_wr  (reg_wr && hit_sen),
        .sig_en_wr  (reg_wr && hit_gen),
        .sts_clr_wr (reg_wr && hit_sts),
        .wbits      (reg_wdata[EV_W-1:0]),
        .ev         (all_ev),
        .status     (irq_status),
        .sts_en     (sts_en_q),
        .sig_en     (sig_en_q),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_pkt)  reg_rdata = pkt_q;
            if (hit_cmd)  reg_rdata = cmd_q;
            if (hit_sen)  reg_rdata = 32'(sts_en_q);
            if (hit_gen)  reg_rdata = 32'(sig_en_q);
            if (hit_sts)  reg_rdata = 32'(irq_status);
            if (hit_data) reg_rdata = dp_rdata;
        end
    end

    assign fl_opc1        = cmd_q.opc1;
    assign fl_opc2        = cmd_q.opc2;
    assign fl_addr_cycles = cmd_q.addr_cycles;
    assign fl_page_bytes  = page_bytes(cmd_q.page_code);
    assign fl_dma         = (cmd_q.xfer_mode == MODE_DMA);

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker
    import flash_pkt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic [OP_W-1:0] fl_op,
    input logic [EV_W-1:0] status,
    input logic [EV_W-1:0] sts_en,
    input logic [2:0]      eng_ev,
    input logic            eng_dma
);

    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fl_op)); // R3

    AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fl_op)); // R4

    AST_LATCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(sts_en)) == '0)); // R10

    AST_DMA_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (eng_dma && busy) |-> (eng_ev[1:0] == 2'b00)); // R9

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_ev[2] |=> busy ##1 !busy); // R12

    AST_EVENT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (eng_ev[2:1] != 2'b00) |-> busy); // R8

endmodule

bind flash_pkt_port fpp_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .fl_op   (fl_op),
    .status  (irq_status),
    .sts_en  (sts_en_q),
    .eng_ev  (eng_ev),
    .eng_dma (eng_dma)
);

// File: tb/test_flash_pkt_port.sv
module test_flash_pkt_port;

    localparam int ADDR_W = 8;
    localparam logic [7:0] A_PKT = 8'h00, A_CMD = 8'h0C, A_PROG = 8'h10,
                           A_SEN = 8'h14, A_GEN = 8'h18, A_STS = 8'h1C, A_DATA = 8'h30;

    // {command word, expected page bytes, expected dma flag}
    localparam logic [48:0] TBL [8] = '{
        {32'h5000_3000, 16'h0200, 1'b0},
        {32'h3880_1080, 16'h0800, 1'b1},
        {32'h2500_0060, 16'h1000, 1'b0},
        {32'h4D80_D060, 16'h2000, 1'b0},
        {32'h1200_00EF, 16'h4000, 1'b0},
        {32'h0A80_0090, 16'h0400, 1'b1},
        {32'h7300_E005, 16'h0000, 1'b0},
        {32'hF380_AA55, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, busy, fl_dma, fin_ready, fout_valid;
    logic [10:0] fl_op;
    logic [7:0]  fl_opc1, fl_opc2, fout_data;
    logic [3:0]  fl_addr_cycles;
    logic [15:0] fl_page_bytes;
    logic        fl_ecc_err = 1'b0, fin_valid = 1'b0, fout_ready = 1'b0;
    logic [7:0]  fin_data = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rv;
    logic [7:0]  bv;

    always #4 clk = ~clk;

    flash_pkt_port #(.MAX_PKT_BYTES(16), .ADDR_W(ADDR_W)) i_flash_pkt_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .busy(busy),
        .fl_op(fl_op), .fl_opc1(fl_opc1), .fl_opc2(fl_opc2),
        .fl_addr_cycles(fl_addr_cycles), .fl_page_bytes(fl_page_bytes), .fl_dma(fl_dma),
        .fl_ecc_err(fl_ecc_err), .fin_valid(fin_valid), .fin_data(fin_data),
        .fin_ready(fin_ready), .fout_valid(fout_valid), .fout_data(fout_data),
        .fout_ready(fout_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        fin_valid = 1'b1; fin_data = b;
        @(negedge clk);
        fin_valid = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b, output logic v);
        @(negedge clk);
        fout_ready = 1'b1;
        #1 b = fout_data; v = fout_valid;
        @(negedge clk);
        fout_ready = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic vld;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 fl_op", {21'b0, fl_op}, 0);
        chk("R1 fin_ready/fout_valid", {30'b0, fin_ready, fout_valid}, 0);
        rd(A_STS, rv);  chk("R1 status", rv, 0);
        rd(A_SEN, rv);  chk("R1 status-enable", rv, 0);
        rd(A_GEN, rv);  chk("R1 signal-enable", rv, 0);
        rd(A_PKT, rv);  chk("R1 packet reg", rv, 0);
        rd(A_CMD, rv);  chk("R1 command reg", rv, 0);

        // R2 command-word decode table
        for (int i = 0; i < 8; i++) begin
            wr(A_CMD, TBL[i][48:17]);
            chk("R2 page bytes", {16'b0, fl_page_bytes}, {16'b0, TBL[i][16:1]});
            chk("R2 dma", {31'b0, fl_dma}, {31'b0, TBL[i][0]});
            chk("R2 opc1", {24'b0, fl_opc1}, {24'b0, TBL[i][24:17]});
            chk("R2 opc2", {24'b0, fl_opc2}, {24'b0, TBL[i][32:25]});
            chk("R2 addr cycles", {28'b0, fl_addr_cycles}, {28'b0, TBL[i][48:45]});
            rd(A_CMD, rv); chk("R2 readback", rv, TBL[i][48:17]);
        end

        // page read, two packets of 8 bytes
        wr(A_SEN, 32'h1F);
        wr(A_GEN, 32'h06);
        wr(A_CMD, 32'h5080_3000);
        wr(A_PKT, 32'h0000_2008);
        wr(A_PROG, 32'h1);
        chk("R3 page read op", {21'b0, fl_op}, 32'h1);
        rd(A_DATA, rv); chk("R6 empty data port", rv, 0);
        for (int i = 0; i < 8; i++) push(8'h11 + 8'(i));
        rd(A_STS, rv); chk("R5 read-ready", rv, 32'h02);
        chk("R11 irq on read-ready", {31'b0, irq}, 1);
        wr(A_PROG, 32'h10);
        chk("R4 op kept while busy", {21'b0, fl_op}, 32'h1);
        rd(A_STS, rv); chk("R4 no status from busy trigger", rv, 32'h02);
        wr(A_STS, 32'h02);
        rd(A_STS, rv); chk("R10 write-one-clear", rv, 0);
        chk("R11 irq low after clear", {31'b0, irq}, 0);
        rd(A_DATA, rv); chk("R5 pkt1 word0 (R6 no advance)", rv, 32'h1413_1211);
        rd(A_DATA, rv); chk("R5 pkt1 word1", rv, 32'h1817_1615);
        rd(A_STS, rv); chk("R8 no complete after first packet", rv, 0);
        for (int i = 0; i < 8; i++) push(8'h21 + 8'(i));
        rd(A_STS, rv); chk("R5 read-ready pkt2", rv, 32'h02);
        wr(A_STS, 32'h02);
        rd(A_DATA, rv); chk("R5 pkt2 word0", rv, 32'h2423_2221);
        rd(A_DATA, rv); chk("R5 pkt2 word1", rv, 32'h2827_2625);
        @(negedge clk); #1;
        chk("R12 busy while complete latched", {31'b0, busy}, 1);
        chk("R11 irq on complete", {31'b0, irq}, 1);
        @(negedge clk); #1;
        chk("R12 busy drops next cycle", {31'b0, busy}, 0);
        rd(A_STS, rv); chk("R8 complete after last packet", rv, 32'h04);
        wr(A_STS, 32'h1F);

        // page program, one packet of 8 bytes
        wr(A_CMD, 32'h0000_1080);
        wr(A_PKT, 32'h0000_1008);
        wr(A_PROG, 32'h10);
        rd(A_STS, rv); chk("R7 write-ready", rv, 32'h01);
        wr(A_STS, 32'h01);
        wr(A_DATA, 32'hA3A2_A1A0);
        wr(A_DATA, 32'hB3B2_B1B0);
        for (int i = 0; i < 8; i++) begin
            pop(bv, vld);
            chk("R7 egress valid", {31'b0, vld}, 1);
            chk("R7 egress byte", {24'b0, bv},
                {24'b0, (i < 4) ? (8'hA0 + 8'(i)) : (8'hB0 + 8'(i - 4))});
        end
        rd(A_STS, rv); chk("R8 program complete", rv, 32'h04);
        wr(A_STS, 32'h1F);

        // DMA read, two packets of 4 bytes
        wr(A_CMD, 32'h0800_0000);
        wr(A_PKT, 32'h0000_2004);
        chk("R9 dma flag", {31'b0, fl_dma}, 1);
        wr(A_PROG, 32'h1);
        for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
        rd(A_STS, rv); chk("R9 no read-ready in dma", rv, 0);
        rd(A_DATA, rv); chk("R9 dma word0", rv, 32'h4342_4140);
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i));
        rd(A_DATA, rv); chk("R9 dma word1", rv, 32'h5352_5150);
        repeat (2) @(negedge clk);
        rd(A_STS, rv); chk("R9 dma complete only", rv, 32'h04);
        wr(A_STS, 32'h1F);

        // status-enable masking with an erase
        wr(A_CMD, 32'h0);
        wr(A_SEN, 32'h1B);
        wr(A_PROG, 32'h4);
        repeat (3) @(negedge clk);
        rd(A_STS, rv); chk("R10 complete masked", rv, 0);
        chk("R8 erase finished", {31'b0, busy}, 0);

        // reset op with signal-enable gating
        wr(A_SEN, 32'h1F);
        wr(A_GEN, 32'h04);
        wr(A_PROG, 32'h100);
        repeat (3) @(negedge clk);
        rd(A_STS, rv); chk("R8 reset op complete", rv, 32'h04);
        chk("R11 irq with signal-enable", {31'b0, irq}, 1);
        wr(A_GEN, 32'h0);
        #1 chk("R11 irq masked", {31'b0, irq}, 0);
        wr(A_STS, 32'h1F);

        // illegal triggers
        wr(A_PROG, 32'h3);
        #1 chk("R3 two bits no start", {31'b0, busy}, 0);
        rd(A_STS, rv); chk("R3 error bit", rv, 32'h10);
        wr(A_STS, 32'h10);
        wr(A_PROG, 32'h2);
        rd(A_STS, rv); chk("R3 undefined bit error", rv, 32'h10);
        wr(A_STS, 32'h10);

        // get feature with zero packet count
        wr(A_PKT, 32'h0000_0008);
        wr(A_PROG, 32'h200);
        #1 chk("R3 get-feature op", {21'b0, fl_op}, 32'h200);
        repeat (2) @(negedge clk);
        rd(A_STS, rv); chk("R8 zero-count complete", rv, 32'h04);
        wr(A_STS, 32'h1F);

        // ECC error pulse
        @(negedge clk) fl_ecc_err = 1'b1;
        @(negedge clk) fl_ecc_err = 1'b0;
        rd(A_STS, rv); chk("R13 ecc status", rv, 32'h08);

        finish_run();
    end

endmodule